// File: doc/BRIEF.md
# Runtime-Constrained Multi-Core Tone Scheduler

This block hands per-subcarrier detection jobs (tones) to a set of parallel tree-search detector cores. Tones arrive one per cycle at most and wait in a flip-flop queue. Every queued tone is visible at once, so one cycle can serve several idle cores. Once a core starts a tone it cannot be stopped. For this reason each dispatch carries a fixed cycle budget, computed at the moment the tone leaves the queue.

The budget is what is left of the symbol's cycle allowance after three deductions: the cycles that finished tones really used, the budgets of tones still running, and a per-tone reserve for every tone of the symbol that comes after this one. The result is then capped by a configurable ceiling. A collector reports each finished tone with its used-cycle count, and the scheduler folds that count into the running sums for later tones. A start-of-symbol pulse clears the sums and the tone index. Four parameters are written through a simple register port: the symbol allowance, the reserve per tone, the ceiling, and the number of tones per symbol.

Top module: `tone_sched`

## Requirements
- R1: Tones are queued in arrival order, up to DEPTH entries. `tone_ready_o` is high exactly when fewer than DEPTH tones are held, and a tone is accepted when `tone_valid_i` and `tone_ready_o` are both high. Dispatched data leaves in acceptance order.
- R2: A core is eligible when its `core_idle_i` bit is high and it has no tone in flight. In one cycle the k-th eligible core, counted from core 0 upward, receives the k-th oldest queued tone, provided that many tones are queued.
- R3: A core that has a tone in flight gets no dispatch until its `done_i` bit is seen. A core whose idle bit is low gets no dispatch.
- R4: The budget of tone n is min(max(A − U − O − kmin·r, 0), kmax). A is the symbol allowance, U is the sum of used cycles reported for this symbol, O is the sum of the budgets of this symbol's tones in flight, and r = M − (n+1) when M > n+1, otherwise 0. M is the number of tones per symbol and n is the tone's index within the symbol, counted from 0.
- R5: When several tones are dispatched in one cycle, each later tone sees the budgets of the earlier ones in that cycle as already outstanding, and its index is one higher.
- R6: If the value before clamping is zero or negative, the budget is 0.
- R7: No budget exceeds kmax.
- R8: A completion (`done_i` of a core with a tone in flight from the current symbol) removes that tone's budget from O and adds `done_used_i` to U. Both changes take effect in the following cycle. `done_i` on a core with nothing in flight has no effect.
- R9: In a cycle with `sym_start_i` high, nothing is dispatched. From the next cycle, U, O and the tone index are 0. Tones from earlier symbols that complete later still free their core but do not change U or O.
- R10: A write with `cfg_we_i` high sets a parameter chosen by `cfg_addr_i`: 0 = allowance A, 1 = kmin, 2 = kmax, 3 = tones per symbol M. The new value is used from the next cycle. All four parameters reset to 0.
- R11: The tone with index n ≥ M−1 reserves nothing for later tones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Parameter write strobe |
| cfg_addr_i | input | 2 | Parameter select |
| cfg_wdata_i | input | CFG_W | Parameter value |
| sym_start_i | input | 1 | Start of a new OFDM symbol |
| tone_valid_i | input | 1 | Incoming tone valid |
| tone_data_i | input | TONE_W | Incoming tone job |
| tone_ready_o | output | 1 | Queue can accept a tone |
| core_idle_i | input | N_CORES | Per-core idle flags |
| done_i | input | N_CORES | Per-core completion strobe from the collector |
| done_used_i | input | N_CORES*CYC_W | Used cycles of each completing core |
| disp_valid_o | output | N_CORES | Per-core dispatch strobe |
| disp_data_o | output | N_CORES*TONE_W | Tone job per core |
| disp_budget_o | output | N_CORES*CYC_W | Cycle budget per dispatched tone |

## Verification
The hardest case is a cycle in which several cores are free at once and the queue holds enough tones to serve them. Each budget in that cycle depends on the ones before it, and completions and symbol starts land in neighbouring cycles. The stimulus produces these by alternating phases. One phase starves the cores so the queue fills to full. Another releases many idle cores together. In all phases completions, ignored completions, symbol starts and parameter writes are mixed in. A bench model recomputes every budget arithmetically. Small allowances and small ceilings are written often, so clamping at zero and capping both occur.

// File: rtl/tone_sched_pkg.sv
package tone_sched_pkg;
  typedef enum logic [1:0] {
    CFG_ALLOW = 2'd0,
    CFG_KMIN  = 2'd1,
    CFG_KMAX  = 2'd2,
    CFG_TONES = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/tsched_cfg.sv
module tsched_cfg
  import tone_sched_pkg::*;
#(
  parameter int unsigned CFG_W = 19,
  parameter int unsigned CYC_W = 12,
  parameter int unsigned TN_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] allow_o,
  output logic [CYC_W-1:0] kmin_o,
  output logic [CYC_W-1:0] kmax_o,
  output logic [TN_W-1:0]  tones_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o <= '0;
      kmin_o  <= '0;
      kmax_o  <= '0;
      tones_o <= '0;
    end else if (we_i) begin
      case (cfg_sel_e'(addr_i))
        CFG_ALLOW: allow_o <= wdata_i;
        CFG_KMIN:  kmin_o  <= wdata_i[CYC_W-1:0];
        CFG_KMAX:  kmax_o  <= wdata_i[CYC_W-1:0];
        default:   tones_o <= wdata_i[TN_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/tsched_fifo.sv
// Flop queue with full random read of the oldest NPOP entries; DEPTH is a power of two.
module tsched_fifo #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NPOP  = 4,
  parameter int unsigned PTR_W = $clog2(DEPTH),
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned NP_W  = $clog2(NPOP + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [W-1:0]    data_i,
  output logic            ready_o,
  input  logic [NP_W-1:0] pop_n_i,
  output logic [CNT_W-1:0] count_o,
  output logic [NPOP*W-1:0] peek_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] head_q;
  logic [CNT_W-1:0] count_q;
  logic [PTR_W-1:0] wr_ptr;
  logic             push;

  assign ready_o = (count_q < CNT_W'(DEPTH));
  assign push    = valid_i & ready_o;
  assign wr_ptr  = head_q + count_q[PTR_W-1:0];
  assign count_o = count_q;

  for (genvar k = 0; k < NPOP; k++) begin : g_peek
    assign peek_o[k*W +: W] = mem_q[head_q + PTR_W'(k)];
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_q + PTR_W'(pop_n_i);
      count_q <= count_q + CNT_W'(push) - CNT_W'(pop_n_i);
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_pop_le_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(pop_n_i) <= count_q);
endmodule

// File: rtl/tsched_alloc.sv
// Ranks eligible cores lowest index first and grants as many as tones are queued.
module tsched_alloc #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned RK_W  = $clog2(N + 1)
) (
  input  logic [N-1:0]      elig_i,
  input  logic [CNT_W-1:0]  avail_i,
  input  logic              block_i,
  output logic [N-1:0]      grant_o,
  output logic [N*RK_W-1:0] rank_o,
  output logic [RK_W-1:0]   ngrant_o
);
  always_comb begin
    int r;
    int g;
    r = 0;
    g = 0;
    grant_o = '0;
    rank_o  = '0;
    for (int i = 0; i < N; i++) begin
      rank_o[i*RK_W +: RK_W] = RK_W'(r);
      if (elig_i[i]) begin
        if (!block_i && (r < int'(avail_i))) begin
          grant_o[i] = 1'b1;
          g++;
        end
        r++;
      end
    end
    ngrant_o = RK_W'(g);
  end
endmodule

// File: rtl/tsched_budget.sv
// Budget chain: rank j sees the budgets of ranks below it as outstanding.
module tsched_budget #(
  parameter int unsigned N     = 4,
  parameter int unsigned CYC_W = 12,
  parameter int unsigned TN_W  = 6,
  parameter int unsigned IDX_W = TN_W + 1,
  parameter int unsigned SW    = CYC_W + TN_W + 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [SW-1:0] base_i,
  input  logic [CYC_W-1:0]     kmin_i,
  input  logic [CYC_W-1:0]     kmax_i,
  input  logic [TN_W-1:0]      tones_i,
  input  logic [IDX_W-1:0]     idx_i,
  output logic [N*CYC_W-1:0]   bud_o
);
  localparam int unsigned PW = CYC_W + IDX_W + 1;

  logic signed [SW-1:0] slack [N+1];
  assign slack[0] = base_i;

  for (genvar j = 0; j < N; j++) begin : g_rank
    logic [IDX_W:0]       nxt;
    logic [IDX_W:0]       tones_x;
    logic [IDX_W:0]       rest;
    logic [PW-1:0]        rsv;
    logic signed [SW-1:0] val;
    logic [CYC_W-1:0]     bud;

    assign nxt     = {1'b0, idx_i} + (IDX_W+1)'(j + 1);
    assign tones_x = (IDX_W+1)'(tones_i);
    assign rest    = (tones_x > nxt) ? (tones_x - nxt) : '0;
    assign rsv     = PW'(kmin_i) * PW'(rest);
    assign val     = slack[j] - $signed(SW'(rsv));

    always_comb begin
      if (val <= 0)                        bud = '0;
      else if (val > $signed(SW'(kmax_i))) bud = kmax_i;
      else                                 bud = val[CYC_W-1:0];
    end

    assign bud_o[j*CYC_W +: CYC_W] = bud;
    assign slack[j+1] = slack[j] - $signed(SW'(bud));

    p_budget_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bud <= kmax_i);
  end
endmodule

// File: rtl/tone_sched.sv
module tone_sched #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned TONE_W  = 10,
  parameter int unsigned CYC_W   = 12,
  parameter int unsigned TN_W    = 6,
  parameter int unsigned CFG_W   = CYC_W + TN_W + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cfg_we_i,
  input  logic [1:0]                cfg_addr_i,
  input  logic [CFG_W-1:0]          cfg_wdata_i,
  input  logic                      sym_start_i,
  input  logic                      tone_valid_i,
  input  logic [TONE_W-1:0]         tone_data_i,
  output logic                      tone_ready_o,
  input  logic [N_CORES-1:0]        core_idle_i,
  input  logic [N_CORES-1:0]        done_i,
  input  logic [N_CORES*CYC_W-1:0]  done_used_i,
  output logic [N_CORES-1:0]        disp_valid_o,
  output logic [N_CORES*TONE_W-1:0] disp_data_o,
  output logic [N_CORES*CYC_W-1:0]  disp_budget_o
);
  localparam int unsigned ACC_W = CFG_W;
  localparam int unsigned IDX_W = TN_W + 1;
  localparam int unsigned SW    = ACC_W + 3;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned RK_W  = $clog2(N_CORES + 1);

  logic [CFG_W-1:0] allow;
  logic [CYC_W-1:0] kmin, kmax;
  logic [TN_W-1:0]  tones;

  logic [N_CORES-1:0]        busy_q, live_q, busy_n, live_n;
  logic [CYC_W-1:0]          held_q [N_CORES];
  logic [ACC_W-1:0]          used_q, out_q, used_n, out_n;
  logic [IDX_W-1:0]          idx_q, idx_n;

  logic [CNT_W-1:0]          fifo_cnt;
  logic [N_CORES*TONE_W-1:0] peek;
  logic [N_CORES-1:0]        elig, grant;
  logic [N_CORES*RK_W-1:0]   rank;
  logic [RK_W-1:0]           ngrant;
  logic [N_CORES*CYC_W-1:0]  rank_bud;
  logic signed [SW-1:0]      base;

  tsched_cfg #(.CFG_W(CFG_W), .CYC_W(CYC_W), .TN_W(TN_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .allow_o(allow), .kmin_o(kmin), .kmax_o(kmax), .tones_o(tones)
  );

  tsched_fifo #(.W(TONE_W), .DEPTH(DEPTH), .NPOP(N_CORES)) u_fifo (
    .clk_i, .rst_ni,
    .valid_i(tone_valid_i), .data_i(tone_data_i), .ready_o(tone_ready_o),
    .pop_n_i(ngrant), .count_o(fifo_cnt), .peek_o(peek)
  );

  assign elig = core_idle_i & ~busy_q;

  tsched_alloc #(.N(N_CORES), .CNT_W(CNT_W)) u_alloc (
    .elig_i(elig), .avail_i(fifo_cnt), .block_i(sym_start_i),
    .grant_o(grant), .rank_o(rank), .ngrant_o(ngrant)
  );

  assign base = $signed(SW'(allow)) - $signed(SW'(used_q)) - $signed(SW'(out_q));

  tsched_budget #(.N(N_CORES), .CYC_W(CYC_W), .TN_W(TN_W), .IDX_W(IDX_W), .SW(SW)) u_budget (
    .clk_i, .rst_ni,
    .base_i(base), .kmin_i(kmin), .kmax_i(kmax), .tones_i(tones), .idx_i(idx_q),
    .bud_o(rank_bud)
  );

  // route rank-ordered tones and budgets to the granted cores
  always_comb begin
    disp_valid_o  = grant;
    disp_data_o   = '0;
    disp_budget_o = '0;
    for (int i = 0; i < N_CORES; i++) begin
      for (int k = 0; k < N_CORES; k++) begin
        if (grant[i] && (rank[i*RK_W +: RK_W] == RK_W'(k))) begin
          disp_data_o[i*TONE_W +: TONE_W]  = peek[k*TONE_W +: TONE_W];
          disp_budget_o[i*CYC_W +: CYC_W]  = rank_bud[k*CYC_W +: CYC_W];
        end
      end
    end
  end

  always_comb begin
    logic [IDX_W:0] isum;
    busy_n = busy_q;
    live_n = live_q;
    used_n = used_q;
    out_n  = out_q;
    for (int i = 0; i < N_CORES; i++) begin
      if (done_i[i] && busy_q[i]) begin
        busy_n[i] = 1'b0;
        live_n[i] = 1'b0;
        if (live_q[i] && !sym_start_i) begin
          out_n  = out_n - ACC_W'(held_q[i]);
          used_n = used_n + ACC_W'(done_used_i[i*CYC_W +: CYC_W]);
        end
      end
    end
    if (sym_start_i) begin
      used_n = '0;
      out_n  = '0;
      live_n = '0;
    end
    for (int i = 0; i < N_CORES; i++) begin
      if (grant[i]) begin
        busy_n[i] = 1'b1;
        live_n[i] = 1'b1;
        out_n     = out_n + ACC_W'(disp_budget_o[i*CYC_W +: CYC_W]);
      end
    end
    isum = {1'b0, idx_q} + (IDX_W+1)'(ngrant);
    if (sym_start_i)    idx_n = '0;
    else if (isum[IDX_W]) idx_n = '1;
    else                idx_n = isum[IDX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      live_q <= '0;
      used_q <= '0;
      out_q  <= '0;
      idx_q  <= '0;
      for (int i = 0; i < N_CORES; i++) held_q[i] <= '0;
    end else begin
      busy_q <= busy_n;
      live_q <= live_n;
      used_q <= used_n;
      out_q  <= out_n;
      idx_q  <= idx_n;
      for (int i = 0; i < N_CORES; i++) begin
        if (grant[i]) held_q[i] <= disp_budget_o[i*CYC_W +: CYC_W];
      end
    end
  end

  p_no_disp_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_i |-> (disp_valid_o == '0));
  p_sums_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_start_i |=> (used_q == '0 && out_q == '0 && idx_q == '0));

  for (genvar i = 0; i < N_CORES; i++) begin : g_chk
    p_disp_needs_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[i] |-> core_idle_i[i]);
    p_no_redispatch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[i] |=> !disp_valid_o[i]);
    p_used_added_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_i[i] && busy_q[i] && live_q[i] && !sym_start_i)
      |=> (used_q >= ACC_W'($past(done_used_i[i*CYC_W +: CYC_W]))));
  end
endmodule

// File: tb/tone_sched_tb.sv
module tone_sched_tb;
  localparam int N = 4, DEPTH = 8, TONE_W = 10, CYC_W = 12, TN_W = 6;
  localparam int CFG_W = CYC_W + TN_W + 1;
  localparam int IDX_MAX = (1 << (TN_W + 1)) - 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic sym_start = 1'b0, tone_valid = 1'b0;
  logic [TONE_W-1:0] tone_data = '0;
  logic tone_ready;
  logic [N-1:0] core_idle = '0, done = '0;
  logic [N*CYC_W-1:0] done_used = '0;
  logic [N-1:0] disp_valid;
  logic [N*TONE_W-1:0] disp_data;
  logic [N*CYC_W-1:0] disp_budget;

  always #10 clk = ~clk;

  tone_sched #(.N_CORES(N), .DEPTH(DEPTH), .TONE_W(TONE_W), .CYC_W(CYC_W), .TN_W(TN_W)) u_dut (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .sym_start_i(sym_start), .tone_valid_i(tone_valid), .tone_data_i(tone_data),
    .tone_ready_o(tone_ready), .core_idle_i(core_idle), .done_i(done), .done_used_i(done_used),
    .disp_valid_o(disp_valid), .disp_data_o(disp_data), .disp_budget_o(disp_budget)
  );

  int n_chk = 0, n_fail = 0;
  int m_busy [N], m_live [N], m_held [N];
  longint m_used = 0, m_out = 0;
  int m_idx = 0, m_tot = 0, m_kmin = 0, m_kmax = 0, m_tones = 0;
  int mq [DEPTH];
  int m_head = 0, m_cnt = 0, tone_seq = 0;
  bit rc_cfg = 0, rc_done = 0;
  int e_grant [N], e_bud [N];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_cycle();
    int j = 0;
    longint acc = 0;
    chk(tone_ready == (m_cnt < DEPTH), "R1 ready", tone_ready, m_cnt < DEPTH);
    for (int i = 0; i < N; i++) begin
      bit eg = core_idle[i] && !m_busy[i] && !sym_start && (j < m_cnt);
      e_grant[i] = eg;
      e_bud[i] = 0;
      chk(disp_valid[i] == eg, sym_start ? "R9 no dispatch" : (eg ? "R2 grant" : "R3 hold"),
          disp_valid[i], eg);
      if (eg) begin
        int n = m_idx + j;
        int res = (m_tones > n + 1) ? m_tones - n - 1 : 0;
        longint v = longint'(m_tot) - m_used - m_out - acc - longint'(m_kmin) * res;
        int b = (v <= 0) ? 0 : ((v > m_kmax) ? m_kmax : int'(v));
        string tag;
        if (v <= 0) tag = "R6 clamp";
        else if (v > m_kmax) tag = "R7 cap";
        else if (rc_cfg) tag = "R10 cfg";
        else if (j > 0) tag = "R5 chain";
        else if (rc_done) tag = "R8 feedback";
        else if (res == 0) tag = "R11 last";
        else tag = "R4 budget";
        chk(disp_data[i*TONE_W +: TONE_W] == TONE_W'(mq[(m_head + j) % DEPTH]), "R1 order",
            disp_data[i*TONE_W +: TONE_W], mq[(m_head + j) % DEPTH]);
        chk(disp_budget[i*CYC_W +: CYC_W] == CYC_W'(b), tag, disp_budget[i*CYC_W +: CYC_W], b);
        e_bud[i] = b;
        acc += b;
        j++;
      end
    end
  endtask

  task automatic model_step();
    int g = 0;
    if (tone_valid && m_cnt < DEPTH) begin
      mq[(m_head + m_cnt) % DEPTH] = int'(tone_data);
      m_cnt++;
    end
    rc_cfg = cfg_we;
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: m_tot = int'(cfg_wdata);
        2'd1: m_kmin = int'(cfg_wdata[CYC_W-1:0]);
        2'd2: m_kmax = int'(cfg_wdata[CYC_W-1:0]);
        default: m_tones = int'(cfg_wdata[TN_W-1:0]);
      endcase
    end
    rc_done = 0;
    for (int i = 0; i < N; i++) begin
      if (done[i] && m_busy[i]) begin
        if (m_live[i] && !sym_start) begin
          m_out -= m_held[i];
          m_used += done_used[i*CYC_W +: CYC_W];
          rc_done = 1;
        end
        m_busy[i] = 0;
        m_live[i] = 0;
      end
    end
    if (sym_start) begin
      m_used = 0; m_out = 0; m_idx = 0;
      for (int i = 0; i < N; i++) m_live[i] = 0;
    end
    for (int i = 0; i < N; i++) begin
      if (e_grant[i]) begin
        m_busy[i] = 1; m_live[i] = 1; m_held[i] = e_bud[i];
        m_out += e_bud[i];
        g++;
      end
    end
    m_head = (m_head + g) % DEPTH;
    m_cnt -= g;
    if (!sym_start) m_idx = (m_idx + g > IDX_MAX) ? IDX_MAX : m_idx + g;
  endtask

  task automatic cfg_cycle(input int addr, input int val);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 2'(addr); cfg_wdata = CFG_W'(val);
    #1 check_cycle();
    model_step();
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_live[i] = 0; m_held[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    chk(tone_ready == 1'b1, "R1 reset ready", tone_ready, 1);
    chk(disp_valid == '0, "R3 reset idle", disp_valid, 0);
    rst_ni = 1'b1;
    cfg_cycle(0, 5000);
    cfg_cycle(1, 50);
    cfg_cycle(2, 900);
    cfg_cycle(3, 16);
    begin
      int sym_len = 40, sym_cnt = 0;
      for (int c = 0; c < 24000; c++) begin
        int ph = (c / 400) % 4;
        @(negedge clk);
        sym_cnt++;
        sym_start = (sym_cnt >= sym_len);
        if (sym_start) begin sym_cnt = 0; sym_len = 20 + $urandom % 60; end
        cfg_we = ($urandom % 16 == 0);
        cfg_addr = 2'($urandom % 4);
        case (cfg_addr)
          2'd0: cfg_wdata = CFG_W'(($urandom % 4 == 0) ? $urandom % 200 : $urandom % 20000);
          2'd1: cfg_wdata = CFG_W'($urandom % 300);
          2'd2: cfg_wdata = CFG_W'(($urandom % 4 == 0) ? $urandom % 50 : $urandom % 4096);
          default: cfg_wdata = CFG_W'(1 + $urandom % 40);
        endcase
        tone_valid = (ph == 0) ? ($urandom % 8 == 0) : (ph == 1) ? 1'b1 : ($urandom % 2 == 0);
        tone_data = TONE_W'(tone_seq);
        if (tone_valid && tone_ready) tone_seq++;
        for (int i = 0; i < N; i++) begin
          core_idle[i] = (ph == 0) ? 1'b1 : (ph == 1) ? ($urandom % 10 == 0) : ($urandom % 2 == 0);
          done[i] = ($urandom % 3 == 0);
          done_used[i*CYC_W +: CYC_W] = CYC_W'($urandom % 512);
        end
        #1 check_cycle();
        model_step();
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule